// File: doc/BRIEF.md
# Dual-Clock RAM with Selectable Word Width

This block is a 256-bit memory with one write port and one read port. Each port runs on its own clock. A static mode input organises the storage either as 64 words of 4 bits or as 32 words of 8 bits. Both views use the same cells, so a byte written in the wide mode can be read back as two nibbles in the narrow mode, and the reverse also works. Each port has a polarity input that sets which edge of its clock the port acts on: rising or falling.

The control module turns port addresses into a row index and lane selects. The datapath holds the storage, split into nibble-wide lanes, and the registered read output. The mode and polarity inputs are configuration. Change them only while both enables are low. An active-low reset clears only the read register. The storage cells are never cleared.

Top module: `dpram_dual_aspect`

## Requirements
- R1: In byte mode (`byteMode`=1), a write with `wrEn` high stores all 8 bits of `wrData` at word `wrAddr[4:0]`. A later read of that word returns the same 8 bits.
- R2: In nibble mode (`byteMode`=0), a write stores only `wrData[3:0]`. A read returns the stored nibble on `rdData[3:0]`, and `rdData[7:4]` is 0.
- R3: In byte mode, address bit 5 has no effect on either port. Addresses A and A+32 refer to the same word.
- R4: Nibble address A maps onto byte address A>>1. When A[0]=0 it is bits 3:0 of that byte, and when A[0]=1 it is bits 7:4. Data crosses between modes in both directions under this mapping.
- R5: While `wrEn` is low, no storage cell changes, whatever the write address and write data are.
- R6: While `rdEn` is low, `rdData` holds its value even if `rdAddr` changes.
- R7: A port with its polarity input at 0 acts on the rising edge of its clock. With the polarity input at 1 it acts on the falling edge only. The two ports are set independently.
- R8: When a write and a read hit the same address on the same active edge, the read returns the contents from before the write. The next read returns the new data.
- R9: While `rstN` is low, `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset of the read register |
| byteMode | input | 1 | 1: 32x8 organisation, 0: 64x4 organisation |
| wrClk | input | 1 | Write port clock |
| wrClkFall | input | 1 | 1: write port acts on falling edge of wrClk |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 6 | Write address |
| wrData | input | 8 | Write data |
| rdClk | input | 1 | Read port clock |
| rdClkFall | input | 1 | 1: read port acts on falling edge of rdClk |
| rdEn | input | 1 | Read enable |
| rdAddr | input | 6 | Read address |
| rdData | output | 8 | Registered read data |

## Verification
The hardest case to reach from the ports is a read and a write landing on the same cell at the very same active edge. The bench ties both port clocks to one source and gives both ports the same polarity setting. It then raises both enables, with equal addresses, in a single setup slot. It does this once for each polarity and checks both the old value and the following new value.

Edge selection is the other subtle case. Inputs are held across the edge that should be ignored and sampled between the two edges. This shows that a falling-edge port neither writes nor reads on a rising edge.

// File: rtl/dpram_pkg.sv
`timescale 1ns/1ps
package dpram_pkg;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned LANE_W     = 4;
  localparam int unsigned TOTAL_BITS = 256;
  localparam int unsigned LANES      = DATA_W / LANE_W;
  localparam int unsigned ROWS       = TOTAL_BITS / DATA_W;
  localparam int unsigned ROW_W      = $clog2(ROWS);
  localparam int unsigned LANE_SEL_W = $clog2(LANES);
  localparam int unsigned ADDR_W     = ROW_W + LANE_SEL_W;

  typedef struct packed {
    logic              en;
    logic [ROW_W-1:0]  row;
    logic [LANES-1:0]  laneMask;
    logic [DATA_W-1:0] data;
  } wrStrobe_t;

  typedef struct packed {
    logic                  en;
    logic [ROW_W-1:0]      row;
    logic [LANE_SEL_W-1:0] lane;
    logic                  wide;
  } rdStrobe_t;
endpackage

// File: rtl/dpram_ctrl.sv
`timescale 1ns/1ps
module dpram_ctrl
  import dpram_pkg::*;
(
  input  logic              byteMode,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output wrStrobe_t         wrStrb,
  output rdStrobe_t         rdStrb
);
  // Write side: pick row, lane mask and lane-replicated data
  always_comb begin
    wrStrb.en = wrEn;
    if (byteMode) begin
      wrStrb.row      = wrAddr[ROW_W-1:0];
      wrStrb.laneMask = '1;
      wrStrb.data     = wrData;
    end else begin
      wrStrb.row      = wrAddr[ADDR_W-1 -: ROW_W];
      wrStrb.laneMask = LANES'(1) << wrAddr[LANE_SEL_W-1:0];
      wrStrb.data     = {LANES{wrData[LANE_W-1:0]}};
    end
  end

  // Read side: row plus lane select; wide flag picks the output format
  always_comb begin
    rdStrb.en   = rdEn;
    rdStrb.wide = byteMode;
    rdStrb.lane = rdAddr[LANE_SEL_W-1:0];
    if (byteMode) rdStrb.row = rdAddr[ROW_W-1:0];
    else          rdStrb.row = rdAddr[ADDR_W-1 -: ROW_W];
  end
endmodule

// File: rtl/dpram_core.sv
`timescale 1ns/1ps
module dpram_core
  import dpram_pkg::*;
(
  input  logic              wrClkEff,
  input  logic              rdClkEff,
  input  logic              rstN,
  input  wrStrobe_t         wrStrb,
  input  rdStrobe_t         rdStrb,
  output logic [DATA_W-1:0] rdData
);
  logic [LANE_W-1:0] laneRd [LANES];
  logic [DATA_W-1:0] rdNext;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] store [ROWS];

    always_ff @(posedge wrClkEff) begin
      if (wrStrb.en && wrStrb.laneMask[g])
        store[wrStrb.row] <= wrStrb.data[g*LANE_W +: LANE_W];
    end

    assign laneRd[g] = store[rdStrb.row];

    // A selected lane holds the written nibble after the write edge
    assert_lane_write_R1: assert property (@(posedge wrClkEff) disable iff (!rstN)
      (wrStrb.en && wrStrb.laneMask[g]) |=>
        store[$past(wrStrb.row)] == $past(wrStrb.data[g*LANE_W +: LANE_W]));
  end

  always_comb begin
    rdNext = '0;
    if (rdStrb.wide) begin
      for (int i = 0; i < LANES; i++) rdNext[i*LANE_W +: LANE_W] = laneRd[i];
    end else begin
      rdNext[LANE_W-1:0] = laneRd[rdStrb.lane];
    end
  end

  // Registered read: array read uses pre-edge contents (read-before-write)
  always_ff @(posedge rdClkEff or negedge rstN) begin
    if (!rstN)           rdData <= '0;
    else if (rdStrb.en)  rdData <= rdNext;
  end

  assert_hold_idle_R6: assert property (@(posedge rdClkEff) disable iff (!rstN)
    !rdStrb.en |=> $stable(rdData));

  assert_narrow_upper_zero_R2: assert property (@(posedge rdClkEff) disable iff (!rstN)
    (rdStrb.en && !rdStrb.wide) |=> rdData[DATA_W-1:LANE_W] == '0);
endmodule

// File: rtl/dpram_dual_aspect.sv
`timescale 1ns/1ps
module dpram_dual_aspect
  import dpram_pkg::*;
(
  input  logic              rstN,
  input  logic              byteMode,
  input  logic              wrClk,
  input  logic              wrClkFall,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdClk,
  input  logic              rdClkFall,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  wrStrobe_t wrStrb;
  rdStrobe_t rdStrb;
  logic      wrClkEff;
  logic      rdClkEff;

  // Edge selection: inverting a clock turns its falling edge into the active one
  assign wrClkEff = wrClk ^ wrClkFall;
  assign rdClkEff = rdClk ^ rdClkFall;

  dpram_ctrl i_ctrl (
    .byteMode (byteMode),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .wrStrb   (wrStrb),
    .rdStrb   (rdStrb)
  );

  dpram_core i_core (
    .wrClkEff (wrClkEff),
    .rdClkEff (rdClkEff),
    .rstN     (rstN),
    .wrStrb   (wrStrb),
    .rdStrb   (rdStrb),
    .rdData   (rdData)
  );

  assert_narrow_one_lane_R2: assert property (@(posedge wrClkEff) disable iff (!rstN)
    (wrEn && !byteMode) |-> $countones(wrStrb.laneMask) == 1);

  assert_wide_all_lanes_R1: assert property (@(posedge wrClkEff) disable iff (!rstN)
    (wrEn && byteMode) |-> &wrStrb.laneMask);
endmodule

// File: tb/test_dpram_dual_aspect.sv
`timescale 1ns/1ps
module test_dpram_dual_aspect;
  logic       clk = 1'b0;
  logic       rstN, byteMode, wrFall, rdFall, wrEn, rdEn;
  logic [5:0] wrAddr, rdAddr;
  logic [7:0] wrData, rdData;
  logic [7:0] refMem [32];
  int runCount = 0;
  int failCount = 0;

  always #2 clk = ~clk;

  dpram_dual_aspect i_dpram_dual_aspect (
    .rstN(rstN), .byteMode(byteMode),
    .wrClk(clk), .wrClkFall(wrFall), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdClk(clk), .rdClkFall(rdFall), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    runCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle(input logic fall);
    if (fall) @(posedge clk); else @(negedge clk);
  endtask

  task automatic doWrite(input logic [5:0] a, input logic [7:0] d);
    idle(wrFall); wrEn = 1'b1; wrAddr = a; wrData = d;
    idle(wrFall); wrEn = 1'b0;
  endtask

  task automatic doRead(input logic [5:0] a, output logic [7:0] q);
    idle(rdFall); rdEn = 1'b1; rdAddr = a;
    idle(rdFall); rdEn = 1'b0; q = rdData;
  endtask

  function automatic logic [7:0] nibExp(input logic [5:0] a);
    logic [7:0] b = refMem[a[5:1]];
    return a[0] ? {4'h0, b[7:4]} : {4'h0, b[3:0]};
  endfunction

  initial begin
    #800000;
    failCount++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end

  initial begin
    logic [7:0] q;
    rstN = 1'b0; byteMode = 1'b1; wrFall = 1'b0; rdFall = 1'b0;
    wrEn = 1'b0; rdEn = 1'b0; wrAddr = '0; rdAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset", rdData, 8'h00);
    rstN = 1'b1;

    // R1 / R3: byte mode sweep, read all 64 addresses
    for (int a = 0; a < 32; a++) begin
      refMem[a] = 8'(a * 37 + 5);
      doWrite(6'(a), refMem[a]);
    end
    for (int a = 0; a < 64; a++) begin
      doRead(6'(a), q);
      chk(a < 32 ? "R1 byte readback" : "R3 bit5 ignored on read", q, refMem[a % 32]);
    end
    doWrite(6'h23, 8'h5C); refMem[3] = 8'h5C;
    doRead(6'h03, q);
    chk("R3 bit5 ignored on write", q, 8'h5C);

    // R4: nibble view of byte-written data
    byteMode = 1'b0;
    for (int a = 0; a < 64; a++) begin
      doRead(6'(a), q);
      chk("R4 byte to nibble", q, nibExp(6'(a)));
    end
    // R2: nibble writes with upper bits set, nibble readback
    for (int a = 0; a < 64; a++) begin
      logic [7:0] d = 8'(a * 11 + 160);
      doWrite(6'(a), d);
      if (a % 2 == 1) refMem[a / 2][7:4] = d[3:0];
      else            refMem[a / 2][3:0] = d[3:0];
    end
    for (int a = 0; a < 64; a++) begin
      doRead(6'(a), q);
      chk("R2 nibble readback", q, nibExp(6'(a)));
    end
    // R4: byte view of nibble-written data
    byteMode = 1'b1;
    for (int a = 0; a < 32; a++) begin
      doRead(6'(a), q);
      chk("R4 nibble to byte", q, refMem[a]);
    end

    // R5: write enable low, address and data present
    idle(wrFall); wrAddr = 6'd7; wrData = ~refMem[7]; wrEn = 1'b0;
    repeat (4) idle(wrFall);
    doRead(6'd7, q);
    chk("R5 no write when disabled", q, refMem[7]);

    // R6: read enable low, address moves
    doRead(6'd9, q);
    idle(rdFall); rdAddr = 6'd10;
    repeat (3) idle(rdFall);
    chk("R6 hold while idle", rdData, refMem[9]);

    // R8: coincident read and write, rising edges
    idle(1'b0);
    wrEn = 1'b1; wrAddr = 6'd12; wrData = ~refMem[12];
    rdEn = 1'b1; rdAddr = 6'd12;
    idle(1'b0); wrEn = 1'b0; rdEn = 1'b0;
    chk("R8 old data rising", rdData, refMem[12]);
    refMem[12] = ~refMem[12];
    doRead(6'd12, q);
    chk("R8 new data rising", q, refMem[12]);

    // R8: coincident read and write, falling edges
    wrFall = 1'b1; rdFall = 1'b1;
    idle(1'b1);
    wrEn = 1'b1; wrAddr = 6'd13; wrData = ~refMem[13];
    rdEn = 1'b1; rdAddr = 6'd13;
    idle(1'b1); wrEn = 1'b0; rdEn = 1'b0;
    chk("R8 old data falling", rdData, refMem[13]);
    refMem[13] = ~refMem[13];
    doRead(6'd13, q);
    chk("R8 new data falling", q, refMem[13]);

    // R7: falling-edge ports ignore the rising edge
    doWrite(6'd20, 8'h3C); refMem[20] = 8'h3C;
    doRead(6'd21, q);
    chk("R7 falling write and read", q, refMem[21]);
    @(negedge clk); #0.5;
    rdEn = 1'b1; rdAddr = 6'd20;
    @(posedge clk); #1;
    chk("R7 read ignores rising edge", rdData, refMem[21]);
    @(negedge clk); #1;
    rdEn = 1'b0;
    chk("R7 read on falling edge", rdData, 8'h3C);
    @(negedge clk); #0.5;
    wrEn = 1'b1; wrAddr = 6'd20; wrData = 8'hA5;
    @(posedge clk); #1;
    wrEn = 1'b0;
    doRead(6'd20, q);
    chk("R7 write ignores rising edge", q, 8'h3C);

    // R7: mixed polarity, write rising and read falling
    wrFall = 1'b0; rdFall = 1'b1;
    doWrite(6'd22, 8'hC3); refMem[22] = 8'hC3;
    doRead(6'd22, q);
    chk("R7 mixed polarity", q, 8'hC3);
    wrFall = 1'b1; rdFall = 1'b0;
    doWrite(6'd23, 8'h96); refMem[23] = 8'h96;
    doRead(6'd23, q);
    chk("R7 mixed polarity swapped", q, 8'h96);

    // R9: reset mid-run clears the read register
    @(negedge clk); #0.5;
    rstN = 1'b0; #1;
    chk("R9 reset mid-run", rdData, 8'h00);
    @(negedge clk); rstN = 1'b1;

    $display("[TB] %0d tests run, %0d failed", runCount, failCount);
    $finish;
  end
endmodule